// File: doc/BRIEF.md
# Address Security Attribution Checker

This block classifies every 32-bit transaction address into a security attribute. The top four address bits name one of sixteen regions, and the parity of that region number decides whether the region is secure. Two of the secure regions can be made non-secure-callable, which marks them as entry points from non-secure code. A narrow window at the base of each of the two highest regions is exempt from the fixed attribution. All attribute outputs are combinational, so a lookup finishes in the cycle it is issued.

The fixed attribute is merged with an attribute that arrives from the processor's own attribution logic. The merge can only make the result more secure: the result is secure when either source marks the address secure. On exempt addresses the processor's attribute passes through unchanged. A 2-bit register selects which callable regions are enabled. Software programs it through an APB-style slave, and reset clears it.

Top module: `sec_attr_unit`

## Requirements
- R1: `region_id` always equals `look_addr[31:28]`.
- R2: `fixed_ns` is 1 exactly when `look_addr[28]` is 0 (even regions are non-secure, odd regions are secure).
- R3: `fixed_nsc` is 1 only for region 1 when configuration bit 0 is 1, or for region 3 when configuration bit 1 is 1. It is 0 in every other case.
- R4: `exempt` is 1 exactly for addresses 0xE0000000..0xE00FFFFF and 0xF0000000..0xF00FFFFF, that is when `(look_addr & 0xEFF00000) == 0xE0000000`.
- R5: The configuration register resets to 0. It sits at byte offset 0x0. A write there stores `pwdata[1:0]`, and a read there returns the register in bits [1:0] with all upper bits zero.
- R6: A write to any offset other than 0x0 leaves the configuration unchanged, and a read from such an offset returns 0.
- R7: For a non-exempt address, `final_ns = fixed_ns & core_ns`. The result is secure when either source says secure.
- R8: For a non-exempt address, `final_nsc` is 1 only when `final_ns` is 0 and every source that marks the address secure also marks it callable: `final_nsc = !final_ns & (fixed_ns | fixed_nsc) & (core_ns | core_nsc)`.
- R9: For an exempt address, `final_ns = core_ns` and `final_nsc = core_nsc`.
- R10: A lookup made in the same cycle as a register write sees the old configuration. The new value applies from the cycle after the write's access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | REG_AW | Register byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| look_addr | input | 32 | Address to classify |
| core_ns | input | 1 | Processor attribution: non-secure |
| core_nsc | input | 1 | Processor attribution: callable (meaningful when core_ns is 0) |
| region_id | output | 4 | Region number of look_addr |
| fixed_ns | output | 1 | Fixed attribution: non-secure |
| fixed_nsc | output | 1 | Fixed attribution: callable |
| exempt | output | 1 | Address lies in an exempt window |
| final_ns | output | 1 | Merged attribute: non-secure |
| final_nsc | output | 1 | Merged attribute: callable |

## Verification
The assertions check, on every cycle, the invariants that hold for any input: region pass-through, callable never paired with non-secure, exempt only in the two highest regions, pass-through on exempt addresses, a merged result never less secure than either source, and the register update and hold rules. What the invariants cannot pin down is shown only by the bench's sweeps: the exact exemption boundaries, the mapping from each configuration bit to its region, the merge table for every source combination, and the cycle in which a new configuration takes effect.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;
    localparam int NSC_CNT      = 2;
    localparam int REGION_W     = 4;
    localparam logic [31:0] EXEMPT_MASK  = 32'hEFF0_0000;
    localparam logic [31:0] EXEMPT_MATCH = 32'hE000_0000;

    typedef struct packed {
        logic ns;
        logic nsc;
    } attr_t;

    typedef struct packed {
        logic [NSC_CNT-1:0] nsc_en;
    } cfg_state_t;
endpackage

// File: rtl/sec_cfg_reg.sv
module sec_cfg_reg
    import sec_attr_pkg::*;
#(
    parameter int REG_AW = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NSC_CNT-1:0] nsc_en
);
    localparam int PAD_W = DATA_W - NSC_CNT;

    cfg_state_t st_d, st_q;
    logic       hit_w;
    logic       at_zero;

    always_comb begin
        at_zero = (paddr == '0);
        hit_w   = psel && penable && pwrite && at_zero;
        st_d    = st_q;
        if (hit_w) begin
            st_d.nsc_en = pwdata[NSC_CNT-1:0];
        end
        prdata = at_zero ? {{PAD_W{1'b0}}, st_q.nsc_en} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nsc_en = st_q.nsc_en;

    // R5: a write to offset zero lands in the register
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == '0)
            |=> (nsc_en == $past(pwdata[NSC_CNT-1:0])));

    // R6: writes elsewhere, or reads, leave the register alone
    a_r6_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite && paddr == '0) |=> $stable(nsc_en));
endmodule

// File: rtl/sec_region_decode.sv
module sec_region_decode
    import sec_attr_pkg::*;
(
    input  logic [31:0]          addr,
    input  logic [NSC_CNT-1:0]   nsc_en,
    output logic [REGION_W-1:0]  region,
    output attr_t                fixed,
    output logic                 exempt
);
    logic [NSC_CNT-1:0] nsc_hit;

    assign region = addr[31:32-REGION_W];

    for (genvar g = 0; g < NSC_CNT; g++) begin : g_nsc
        localparam logic [REGION_W-1:0] TGT = REGION_W'(2*g + 1);
        assign nsc_hit[g] = nsc_en[g] && (region == TGT);
    end

    always_comb begin
        fixed.ns  = ~region[0];
        fixed.nsc = |nsc_hit;
        exempt    = ((addr & EXEMPT_MASK) == EXEMPT_MATCH);
    end

    // R3: callable is only ever granted on a secure region
    always_comb begin
        a_r3_nsc_secure_only: assert (!(fixed.nsc && fixed.ns));
    end
endmodule

// File: rtl/sec_attr_merge.sv
module sec_attr_merge
    import sec_attr_pkg::*;
(
    input  attr_t fixed,
    input  attr_t core,
    input  logic  exempt,
    output attr_t merged
);
    logic fix_ok, core_ok;

    always_comb begin
        fix_ok  = fixed.ns | fixed.nsc;
        core_ok = core.ns | core.nsc;
        if (exempt) begin
            merged = core;
        end else begin
            merged.ns  = fixed.ns & core.ns;
            merged.nsc = ~merged.ns & fix_ok & core_ok;
        end
    end
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
    import sec_attr_pkg::*;
#(
    parameter int REG_AW = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [31:0]       look_addr,
    input  logic              core_ns,
    input  logic              core_nsc,
    output logic [3:0]        region_id,
    output logic              fixed_ns,
    output logic              fixed_nsc,
    output logic              exempt,
    output logic              final_ns,
    output logic              final_nsc
);
    logic [NSC_CNT-1:0] nsc_en;
    attr_t fixed_a, core_a, merged_a;

    assign core_a.ns  = core_ns;
    assign core_a.nsc = core_nsc;

    sec_cfg_reg #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .nsc_en(nsc_en)
    );

    sec_region_decode u_dec (
        .addr(look_addr), .nsc_en(nsc_en), .region(region_id),
        .fixed(fixed_a), .exempt(exempt)
    );

    sec_attr_merge u_merge (
        .fixed(fixed_a), .core(core_a), .exempt(exempt), .merged(merged_a)
    );

    assign fixed_ns  = fixed_a.ns;
    assign fixed_nsc = fixed_a.nsc;
    assign final_ns  = merged_a.ns;
    assign final_nsc = merged_a.nsc;

    // R1: region id tracks the top nibble
    a_r1_region_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        region_id == look_addr[31:28]);

    // R4: exemption only inside the two highest regions
    a_r4_exempt_high: assert property (@(posedge clk) disable iff (!rst_n)
        exempt |-> (region_id[3:1] == 3'b111));

    // R7: merged result never less secure than either source
    a_r7_never_weaker: assert property (@(posedge clk) disable iff (!rst_n)
        (!exempt && final_ns) |-> (fixed_ns && core_ns));

    // R8: callable never paired with non-secure
    a_r8_nsc_secure: assert property (@(posedge clk) disable iff (!rst_n)
        final_nsc |-> !final_ns);

    // R9: exempt addresses carry the processor attribute
    a_r9_exempt_pass: assert property (@(posedge clk) disable iff (!rst_n)
        exempt |-> (final_ns == core_ns && final_nsc == core_nsc));
endmodule

// File: tb/tb_sec_attr_unit.sv
module tb_sec_attr_unit;
    localparam int REG_AW = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [REG_AW-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic [31:0]       look_addr = '0;
    logic              core_ns = 1'b0, core_nsc = 1'b0;
    logic [3:0]        region_id;
    logic              fixed_ns, fixed_nsc, exempt, final_ns, final_nsc;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    sec_attr_unit #(.REG_AW(REG_AW), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .look_addr(look_addr), .core_ns(core_ns), .core_nsc(core_nsc),
        .region_id(region_id), .fixed_ns(fixed_ns), .fixed_nsc(fixed_nsc),
        .exempt(exempt), .final_ns(final_ns), .final_nsc(final_nsc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h act=%h exp=%h", req, look_addr, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [REG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // check every output against values derived from the requirements
    task automatic check_lookup(input logic [1:0] cfg);
        logic [3:0] rg;
        logic e_ns, e_nsc, e_ex, m_ns, m_nsc;
        #1;
        rg    = look_addr[31:28];
        e_ns  = (look_addr[28] == 1'b0);
        e_nsc = (rg == 4'd1 && cfg[0]) || (rg == 4'd3 && cfg[1]);
        e_ex  = (look_addr[31:29] == 3'b111) && (look_addr[27:20] == 8'h00);
        if (e_ex) begin
            m_ns = core_ns; m_nsc = core_nsc;
        end else begin
            m_ns  = e_ns && core_ns;
            m_nsc = !m_ns && (e_ns || e_nsc) && (core_ns || core_nsc);
        end
        chk("R1", 32'(region_id), 32'(rg));
        chk("R2", 32'(fixed_ns), 32'(e_ns));
        chk("R3", 32'(fixed_nsc), 32'(e_nsc));
        chk("R4", 32'(exempt), 32'(e_ex));
        if (e_ex) begin
            chk("R9 ns", 32'(final_ns), 32'(m_ns));
            chk("R9 nsc", 32'(final_nsc), 32'(m_nsc));
        end else begin
            chk("R7", 32'(final_ns), 32'(m_ns));
            chk("R8", 32'(final_nsc), 32'(m_nsc));
        end
    endtask

    initial begin
        logic [31:0] offs [4];
        offs[0] = 32'h0000_0000; offs[1] = 32'h000F_FFFF;
        offs[2] = 32'h0010_0000; offs[3] = 32'h0FFF_FFFF;

        // R5: reset value readable at offset zero
        #20;
        chk("R5 reset", prdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset after release", prdata, 32'h0);

        for (int c = 0; c < 4; c++) begin
            apb(1'b1, '0, 32'hFFFF_FFF0 | 32'(c));
            paddr = '0;
            #1;
            chk("R5 readback", prdata, 32'(c));
            for (int r = 0; r < 16; r++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int k = 0; k < 4; k++) begin
                        look_addr = {r[3:0], 28'h0} | offs[o];
                        core_ns = k[0]; core_nsc = k[1];
                        check_lookup(2'(c));
                    end
                end
            end
            // boundary just below the lower exempt window
            look_addr = 32'hDFFF_FFFF; core_ns = 1'b1; core_nsc = 1'b0;
            check_lookup(2'(c));
        end

        // R6: writes elsewhere ignored, reads elsewhere zero
        apb(1'b1, '0, 32'h1);
        apb(1'b1, 12'h004, 32'h2);
        paddr = 12'h004;
        #1;
        chk("R6 read other", prdata, 32'h0);
        paddr = '0;
        #1;
        chk("R6 write other ignored", prdata, 32'h1);
        look_addr = 32'h3000_0000; core_ns = 1'b1; core_nsc = 1'b0;
        check_lookup(2'b01);

        // R10: old value seen during the write cycle, new value after
        look_addr = 32'h3000_0010; core_ns = 1'b1;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = '0; pwdata = 32'h2;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk("R10 old value", 32'(fixed_nsc), 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        chk("R10 new value", 32'(fixed_nsc), 32'h1);
        check_lookup(2'b10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule